// File: doc/BRIEF.md
# Minimum-Size Component Merge Pass

This block runs the second agglomeration pass of a graph-based image segmenter. A threshold pass before it leaves a union-find forest in three vertex attribute memories: parent label, rank and component size. The block walks the same weight-sorted edge list again. For each edge it finds the root of both endpoints. It joins the two components when they are distinct and at least one of them holds fewer vertices than a programmable minimum. The edge weight plays no part in this pass, so the edge port carries only the two vertex indices.

The memories sit outside the block. The block drives a read port on the edge memory, one shared read port that returns label, rank and size for a single vertex address, a label write port, and a root write port that updates size and rank. Both memories answer a read one cycle after the request. A start pulse launches the pass over the first `edge_count` edges. A one-cycle `done` pulse marks the end, after which the memories hold the merged forest. Recolouring of the image is left to later logic.

Top module: `msm_size_merge`

## Requirements
- R1: After reset, `busy`, `done`, `edge_rd`, `attr_rd`, `lbl_we`, `sz_we` and `rk_we` are all low, and they stay low until a start is accepted.
- R2: `start` is accepted only while `busy` is low. A start pulse while a pass is running has no effect on its write sequence or its timing.
- R3: Edges are read exactly once each, at addresses 0, 1, ... `edge_count`-1 in ascending order.
- R4: The root of a vertex is found by following parent labels from that vertex until a vertex whose label equals its own index is reached. The root of the first endpoint is found before the root of the second.
- R5: Two roots ra (first endpoint) and rb are joined only when ra != rb and (size[ra] < `min_size` or size[rb] < `min_size`), compared unsigned. Otherwise the edge causes no write, and with `min_size` = 0 a pass writes nothing.
- R6: In a join, if rank[ra] < rank[rb] then label[ra] := rb. Otherwise label[rb] := ra. When the two ranks are equal, rank[ra] := rank[ra]+1 in the same cycle. The ranks are otherwise untouched.
- R7: In a join, the surviving root's size is written as size[ra]+size[rb], in the same cycle as the label write.
- R8: `done` is high for exactly one cycle, the cycle after the last edge's join cycle, and `busy` falls in the following cycle. With `edge_count` = 0, `done` is high in the cycle after the start is accepted.
- R9: Each edge takes 5+ha+hb cycles, where ha and hb are the numbers of parent links followed to reach the two roots: one edge read, one capture, ha+1 and hb+1 find cycles, and one join cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that launches a pass when idle |
| edge_count | input | EAW+1 | Number of edges to process |
| min_size | input | SW | Components smaller than this are merged |
| edge_rd | output | 1 | Edge memory read strobe |
| edge_addr | output | EAW | Edge memory read address |
| edge_va | input | VAW | First endpoint, valid one cycle after the read |
| edge_vb | input | VAW | Second endpoint, valid one cycle after the read |
| attr_rd | output | 1 | Attribute read strobe |
| attr_addr | output | VAW | Attribute read vertex address |
| lbl_rdata | input | VAW | Parent label of the addressed vertex |
| rank_rdata | input | RW | Rank of the addressed vertex |
| size_rdata | input | SW | Size of the addressed vertex |
| lbl_we | output | 1 | Label write enable |
| lbl_waddr | output | VAW | Vertex whose label is rewritten |
| lbl_wdata | output | VAW | New parent label |
| sz_we | output | 1 | Size write enable at `root_waddr` |
| rk_we | output | 1 | Rank write enable at `root_waddr` |
| root_waddr | output | VAW | Surviving root address |
| sz_wdata | output | SW | New size of the surviving root |
| rk_wdata | output | RW | New rank of the surviving root |
| busy | output | 1 | Pass in progress (including the done cycle) |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
The assertions assume that the attribute memories hold a well-formed forest. Every parent chain must reach a self-labelled root in fewer than NV steps, and the root sizes must sum to at most NV so that no size overflows. They also assume that edge endpoints index stored vertices. The bench builds each starting forest by applying its own rank-based unions to an identity forest, draws all endpoints from that vertex range, and keeps the memories unchanged by anything but the block while a pass runs.

// File: rtl/msm_pkg.sv
package msm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EREAD,
    ST_ECAP,
    ST_FA,
    ST_FB,
    ST_JOIN,
    ST_FIN
  } msm_state_e;

  typedef enum logic [1:0] {
    LK_NONE,
    LK_A_UNDER_B,
    LK_B_UNDER_A,
    LK_B_UNDER_A_BUMP
  } msm_link_e;

endpackage

// File: rtl/msm_ctrl.sv
module msm_ctrl
  import msm_pkg::*;
#(
  parameter int EAW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [EAW:0]   edge_count,
  input  logic           root_hit,
  output msm_state_e     state,
  output logic           edge_rd,
  output logic [EAW-1:0] edge_addr,
  output logic           busy,
  output logic           done
);

  msm_state_e     state_q, state_d;
  logic [EAW-1:0] idx_q;
  logic [EAW:0]   count_q;
  logic           last_edge;

  assign last_edge = ({1'b0, idx_q} == (count_q - 1'b1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = (edge_count == '0) ? ST_FIN : ST_EREAD;
      ST_EREAD: state_d = ST_ECAP;
      ST_ECAP:  state_d = ST_FA;
      ST_FA:    if (root_hit) state_d = ST_FB;
      ST_FB:    if (root_hit) state_d = ST_JOIN;
      ST_JOIN:  state_d = last_edge ? ST_FIN : ST_EREAD;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      count_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start) begin
        idx_q   <= '0;
        count_q <= edge_count;
      end else if (state_q == ST_JOIN && !last_edge) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign state     = state_q;
  assign edge_rd   = (state_q == ST_EREAD);
  assign edge_addr = idx_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_FIN);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  assert_edge_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    edge_rd |-> ({1'b0, edge_addr} < count_q));

  assert_count_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(count_q));

endmodule

// File: rtl/msm_find.sv
module msm_find
  import msm_pkg::*;
#(
  parameter int NV  = 64,
  parameter int VAW = 6,
  parameter int RW  = 3,
  parameter int SW  = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  msm_state_e     state,
  input  logic [VAW-1:0] edge_va,
  input  logic [VAW-1:0] edge_vb,
  input  logic [VAW-1:0] lbl_rdata,
  input  logic [RW-1:0]  rank_rdata,
  input  logic [SW-1:0]  size_rdata,
  output logic           attr_rd,
  output logic [VAW-1:0] attr_addr,
  output logic           root_hit,
  output logic [VAW-1:0] root_a,
  output logic [VAW-1:0] root_b,
  output logic [RW-1:0]  rank_a,
  output logic [RW-1:0]  rank_b,
  output logic [SW-1:0]  size_a,
  output logic [SW-1:0]  size_b
);

  localparam int HW = $clog2(NV + 1);

  logic [VAW-1:0] cur_q, vb_q;
  logic           walking;
  logic [HW-1:0]  hops_q;

  assign walking  = (state == ST_FA) || (state == ST_FB);
  assign root_hit = walking && (lbl_rdata == cur_q);

  always_comb begin
    attr_rd   = 1'b0;
    attr_addr = cur_q;
    unique case (state)
      ST_ECAP: begin
        attr_rd   = 1'b1;
        attr_addr = edge_va;
      end
      ST_FA: begin
        attr_rd   = 1'b1;
        attr_addr = root_hit ? vb_q : lbl_rdata;
      end
      ST_FB: begin
        attr_rd   = !root_hit;
        attr_addr = lbl_rdata;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      vb_q   <= '0;
      root_a <= '0;
      root_b <= '0;
      rank_a <= '0;
      rank_b <= '0;
      size_a <= '0;
      size_b <= '0;
      hops_q <= '0;
    end else begin
      if (attr_rd) cur_q <= attr_addr;
      if (state == ST_ECAP) vb_q <= edge_vb;
      if (state == ST_FA && root_hit) begin
        root_a <= cur_q;
        rank_a <= rank_rdata;
        size_a <= size_rdata;
      end
      if (state == ST_FB && root_hit) begin
        root_b <= cur_q;
        rank_b <= rank_rdata;
        size_b <= size_rdata;
      end
      if (walking && !root_hit) hops_q <= hops_q + 1'b1;
      else                      hops_q <= '0;
    end
  end

  assert_walk_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    walking |-> (hops_q < HW'(NV)));

  assert_second_walk_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FA && root_hit) |=> (cur_q == vb_q));

endmodule

// File: rtl/msm_join.sv
module msm_join
  import msm_pkg::*;
#(
  parameter int VAW = 6,
  parameter int RW  = 3,
  parameter int SW  = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           active,
  input  logic [SW-1:0]  min_size,
  input  logic [VAW-1:0] root_a,
  input  logic [VAW-1:0] root_b,
  input  logic [RW-1:0]  rank_a,
  input  logic [RW-1:0]  rank_b,
  input  logic [SW-1:0]  size_a,
  input  logic [SW-1:0]  size_b,
  output logic           lbl_we,
  output logic [VAW-1:0] lbl_waddr,
  output logic [VAW-1:0] lbl_wdata,
  output logic           sz_we,
  output logic           rk_we,
  output logic [VAW-1:0] root_waddr,
  output logic [SW-1:0]  sz_wdata,
  output logic [RW-1:0]  rk_wdata
);

  function automatic logic too_small(input logic [SW-1:0] sa, input logic [SW-1:0] sb,
                                     input logic [SW-1:0] limit);
    return (sa < limit) || (sb < limit);
  endfunction

  function automatic msm_link_e pick_link(input logic [RW-1:0] ka, input logic [RW-1:0] kb);
    if (ka < kb)       return LK_A_UNDER_B;
    else if (ka > kb)  return LK_B_UNDER_A;
    else               return LK_B_UNDER_A_BUMP;
  endfunction

  function automatic logic [SW-1:0] merged_size(input logic [SW-1:0] sa, input logic [SW-1:0] sb);
    return sa + sb;
  endfunction

  msm_link_e link;
  logic      merge;

  assign merge = active && (root_a != root_b) && too_small(size_a, size_b, min_size);
  assign link  = merge ? pick_link(rank_a, rank_b) : LK_NONE;

  always_comb begin
    lbl_we     = 1'b0;
    sz_we      = 1'b0;
    rk_we      = 1'b0;
    lbl_waddr  = root_b;
    lbl_wdata  = root_a;
    root_waddr = root_a;
    sz_wdata   = merged_size(size_a, size_b);
    rk_wdata   = rank_a + 1'b1;
    unique case (link)
      LK_A_UNDER_B: begin
        lbl_we     = 1'b1;
        sz_we      = 1'b1;
        lbl_waddr  = root_a;
        lbl_wdata  = root_b;
        root_waddr = root_b;
      end
      LK_B_UNDER_A: begin
        lbl_we = 1'b1;
        sz_we  = 1'b1;
      end
      LK_B_UNDER_A_BUMP: begin
        lbl_we = 1'b1;
        sz_we  = 1'b1;
        rk_we  = 1'b1;
      end
      default: ;
    endcase
  end

  assert_link_distinct_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lbl_we |-> (lbl_waddr != lbl_wdata) && active);

  assert_size_with_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sz_we |-> lbl_we && (sz_wdata > size_a) && (sz_wdata > size_b) && (root_waddr == lbl_wdata));

  assert_rank_bump_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rk_we |-> sz_we && (rank_a == rank_b) && (root_waddr == root_a));

endmodule

// File: rtl/msm_size_merge.sv
module msm_size_merge
  import msm_pkg::*;
#(
  parameter int NV = 64,
  parameter int NE = 128,
  localparam int VAW = $clog2(NV),
  localparam int EAW = $clog2(NE),
  localparam int RW  = $clog2(VAW + 1),
  localparam int SW  = $clog2(NV + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [EAW:0]   edge_count,
  input  logic [SW-1:0]  min_size,
  output logic           edge_rd,
  output logic [EAW-1:0] edge_addr,
  input  logic [VAW-1:0] edge_va,
  input  logic [VAW-1:0] edge_vb,
  output logic           attr_rd,
  output logic [VAW-1:0] attr_addr,
  input  logic [VAW-1:0] lbl_rdata,
  input  logic [RW-1:0]  rank_rdata,
  input  logic [SW-1:0]  size_rdata,
  output logic           lbl_we,
  output logic [VAW-1:0] lbl_waddr,
  output logic [VAW-1:0] lbl_wdata,
  output logic           sz_we,
  output logic           rk_we,
  output logic [VAW-1:0] root_waddr,
  output logic [SW-1:0]  sz_wdata,
  output logic [RW-1:0]  rk_wdata,
  output logic           busy,
  output logic           done
);

  msm_state_e     state;
  logic           root_hit;
  logic [VAW-1:0] root_a, root_b;
  logic [RW-1:0]  rank_a, rank_b;
  logic [SW-1:0]  size_a, size_b;

  msm_ctrl #(.EAW(EAW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .edge_count (edge_count),
    .root_hit   (root_hit),
    .state      (state),
    .edge_rd    (edge_rd),
    .edge_addr  (edge_addr),
    .busy       (busy),
    .done       (done)
  );

  msm_find #(.NV(NV), .VAW(VAW), .RW(RW), .SW(SW)) u_find (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .edge_va    (edge_va),
    .edge_vb    (edge_vb),
    .lbl_rdata  (lbl_rdata),
    .rank_rdata (rank_rdata),
    .size_rdata (size_rdata),
    .attr_rd    (attr_rd),
    .attr_addr  (attr_addr),
    .root_hit   (root_hit),
    .root_a     (root_a),
    .root_b     (root_b),
    .rank_a     (rank_a),
    .rank_b     (rank_b),
    .size_a     (size_a),
    .size_b     (size_b)
  );

  msm_join #(.VAW(VAW), .RW(RW), .SW(SW)) u_join (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (state == ST_JOIN),
    .min_size   (min_size),
    .root_a     (root_a),
    .root_b     (root_b),
    .rank_a     (rank_a),
    .rank_b     (rank_b),
    .size_a     (size_a),
    .size_b     (size_b),
    .lbl_we     (lbl_we),
    .lbl_waddr  (lbl_waddr),
    .lbl_wdata  (lbl_wdata),
    .sz_we      (sz_we),
    .rk_we      (rk_we),
    .root_waddr (root_waddr),
    .sz_wdata   (sz_wdata),
    .rk_wdata   (rk_wdata)
  );

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !edge_rd && !attr_rd && !lbl_we && !sz_we && !rk_we && !done);

  assert_no_read_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lbl_we |-> !attr_rd && !edge_rd);

endmodule

// File: tb/msm_size_merge_tb.sv
module msm_size_merge_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV  = 64;
  localparam int NE  = 128;
  localparam int VAW = $clog2(NV);
  localparam int EAW = $clog2(NE);
  localparam int RW  = $clog2(VAW + 1);
  localparam int SW  = $clog2(NV + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [EAW:0]   edge_count = '0;
  logic [SW-1:0]  min_size = '0;
  logic           edge_rd, attr_rd, lbl_we, sz_we, rk_we, busy, done;
  logic [EAW-1:0] edge_addr;
  logic [VAW-1:0] edge_va, edge_vb, attr_addr, lbl_rdata, lbl_waddr, lbl_wdata, root_waddr;
  logic [RW-1:0]  rank_rdata, rk_wdata;
  logic [SW-1:0]  size_rdata, sz_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  msm_size_merge #(.NV(NV), .NE(NE)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .edge_count(edge_count), .min_size(min_size),
    .edge_rd(edge_rd), .edge_addr(edge_addr), .edge_va(edge_va), .edge_vb(edge_vb),
    .attr_rd(attr_rd), .attr_addr(attr_addr), .lbl_rdata(lbl_rdata),
    .rank_rdata(rank_rdata), .size_rdata(size_rdata),
    .lbl_we(lbl_we), .lbl_waddr(lbl_waddr), .lbl_wdata(lbl_wdata),
    .sz_we(sz_we), .rk_we(rk_we), .root_waddr(root_waddr),
    .sz_wdata(sz_wdata), .rk_wdata(rk_wdata), .busy(busy), .done(done)
  );

  // memories seen by the block
  int e_va [NE];
  int e_vb [NE];
  int m_lbl [NV];
  int m_rk  [NV];
  int m_sz  [NV];
  // reference copies
  int r_lbl [NV];
  int r_rk  [NV];
  int r_sz  [NV];
  int q_lbl [$];
  int q_sz  [$];
  int q_rk  [$];

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (edge_rd) begin
      edge_va <= VAW'(e_va[edge_addr]);
      edge_vb <= VAW'(e_vb[edge_addr]);
    end
    if (attr_rd) begin
      lbl_rdata  <= VAW'(m_lbl[attr_addr]);
      rank_rdata <= RW'(m_rk[attr_addr]);
      size_rdata <= SW'(m_sz[attr_addr]);
    end
    if (lbl_we) m_lbl[lbl_waddr] = int'(lbl_wdata);
    if (sz_we)  m_sz[root_waddr] = int'(sz_wdata);
    if (rk_we)  m_rk[root_waddr] = int'(rk_wdata);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mroot(int x);
    while (m_lbl[x] != x) x = m_lbl[x];
    return x;
  endfunction

  function automatic int rroot(int x, output int hops);
    hops = 0;
    while (r_lbl[x] != x) begin
      x = r_lbl[x];
      hops++;
    end
    return x;
  endfunction

  // identity forest plus some rank-based unions done directly on the memories
  task automatic prep(input int nunion);
    for (int i = 0; i < NV; i++) begin
      m_lbl[i] = i; m_rk[i] = 0; m_sz[i] = 1;
    end
    for (int k = 0; k < nunion; k++) begin
      int a, b;
      a = mroot($urandom_range(NV-1));
      b = mroot($urandom_range(NV-1));
      if (a != b) begin
        if (m_rk[a] < m_rk[b]) begin
          m_lbl[a] = b; m_sz[b] += m_sz[a];
        end else begin
          m_lbl[b] = a; m_sz[a] += m_sz[b];
          if (m_rk[a] == m_rk[b]) m_rk[a]++;
        end
      end
    end
  endtask

  // returns the cycle, counted from the start edge, in which done must be high
  function automatic int ref_run(int cnt, int ms);
    int n = 1;
    for (int i = 0; i < NV; i++) begin
      r_lbl[i] = m_lbl[i]; r_rk[i] = m_rk[i]; r_sz[i] = m_sz[i];
    end
    q_lbl.delete(); q_sz.delete(); q_rk.delete();
    for (int e = 0; e < cnt; e++) begin
      int ha, hb, ra, rb;
      ra = rroot(e_va[e], ha);
      rb = rroot(e_vb[e], hb);
      n += 5 + ha + hb;
      if (ra != rb && (r_sz[ra] < ms || r_sz[rb] < ms)) begin
        if (r_rk[ra] < r_rk[rb]) begin
          r_lbl[ra] = rb; r_sz[rb] += r_sz[ra];
          q_lbl.push_back(ra * 1024 + rb);
          q_sz.push_back(rb * 1024 + r_sz[rb]);
        end else begin
          r_lbl[rb] = ra; r_sz[ra] += r_sz[rb];
          q_lbl.push_back(rb * 1024 + ra);
          q_sz.push_back(ra * 1024 + r_sz[ra]);
          if (r_rk[ra] == r_rk[rb]) begin
            r_rk[ra]++;
            q_rk.push_back(ra * 1024 + r_rk[ra]);
          end
        end
      end
    end
    return n;
  endfunction

  task automatic run_pass(input int cnt, input int ms, input bit extra_start);
    int n, cyc, next_edge, exp;
    string tag;
    n = ref_run(cnt, ms);
    tag = extra_start ? "R2" : "R9";
    @(negedge clk);
    edge_count = (EAW+1)'(cnt);
    min_size = SW'(ms);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    next_edge = 0;
    while (cyc <= n + 1) begin
      if (extra_start) start = (cyc == 3 || cyc == n);
      chk(tag, int'(done), int'(cyc == n));
      if (cyc == n + 1) chk("R8", int'(busy), 0);
      if (edge_rd) begin
        chk("R3", int'(edge_addr), next_edge);
        next_edge++;
      end
      if (lbl_we) begin
        exp = (q_lbl.size() > 0) ? q_lbl.pop_front() : -1;
        chk("R6", int'(lbl_waddr) * 1024 + int'(lbl_wdata), exp);
      end
      if (sz_we) begin
        exp = (q_sz.size() > 0) ? q_sz.pop_front() : -1;
        chk("R7", int'(root_waddr) * 1024 + int'(sz_wdata), exp);
      end
      if (rk_we) begin
        exp = (q_rk.size() > 0) ? q_rk.pop_front() : -1;
        chk("R6", int'(root_waddr) * 1024 + int'(rk_wdata), exp);
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk("R3", next_edge, cnt);
    chk("R5", q_lbl.size() + q_sz.size() + q_rk.size(), 0);
    for (int i = 0; i < NV; i++) begin
      chk("R4", m_lbl[i], r_lbl[i]);
      chk("R7", m_sz[i], r_sz[i]);
      chk("R6", m_rk[i], r_rk[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    prep(0);
    repeat (3) @(negedge clk);
    // R1: quiet before and after reset release
    chk("R1", int'({busy, done, edge_rd, attr_rd, lbl_we, sz_we, rk_we}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", int'({busy, done, edge_rd, attr_rd, lbl_we, sz_we, rk_we}), 0);

    // chain over 16 fresh vertices, min size 3
    for (int i = 0; i < 15; i++) begin e_va[i] = i; e_vb[i] = i + 1; end
    run_pass(15, 3, 0);

    // empty pass
    run_pass(0, 5, 0);

    // R5: min_size 0 never merges
    prep(20);
    for (int i = 0; i < 30; i++) begin e_va[i] = $urandom_range(NV-1); e_vb[i] = $urandom_range(NV-1); end
    run_pass(30, 0, 0);

    // R2: stray start pulses during a pass
    prep(30);
    for (int i = 0; i < 40; i++) begin e_va[i] = $urandom_range(NV-1); e_vb[i] = $urandom_range(NV-1); end
    run_pass(40, 4, 1);

    // self edges, repeated edges, limit above every size
    prep(10);
    for (int i = 0; i < 24; i++) begin
      e_va[i] = (i % 3 == 0) ? i : $urandom_range(15);
      e_vb[i] = (i % 3 == 0) ? i : $urandom_range(15);
    end
    run_pass(24, NV, 0);

    // deep forest, mid limit
    prep(50);
    for (int i = 0; i < 60; i++) begin e_va[i] = $urandom_range(NV-1); e_vb[i] = $urandom_range(NV-1); end
    run_pass(60, 10, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule